// File: doc/BRIEF.md
# Signed High-Word Multiply Unit

This unit multiplies two signed 32-bit operands and returns only the upper 32 bits of the 64-bit signed result. Before that word is taken, the product can be combined with a 32-bit accumulator operand. The accumulator sits in the upper half of a 64-bit term whose lower half is zero. The product is either added to that term or subtracted from it. A half-LSB rounding bias can also be added first, which turns truncation into round-to-nearest on the kept word.

An operation code selects one of six forms: plain, accumulate or subtract, each with or without rounding. The unit is a fixed two-stage pipeline. Operands presented with `in_valid` are captured on one clock edge, and the result is registered on the next. `out_valid` marks a finished result. A new operation can be issued on every cycle.

Top module: `himul_unit`

## Requirements
- R1: With op code 0, `result` is bits 63:32 of the signed 64-bit product of `mul_a` and `mul_b`. Both operands are two's complement.
- R2: With op code 1, `result` is bits 63:32 of (product + 0x80000000).
- R3: With op code 2, `result` is bits 63:32 of ({acc_in, 32'h0} + product).
- R4: With op code 3, `result` is bits 63:32 of ({acc_in, 32'h0} + product + 0x80000000).
- R5: With op code 4, `result` is bits 63:32 of ({acc_in, 32'h0} - product).
- R6: With op code 5, `result` is bits 63:32 of ({acc_in, 32'h0} - product + 0x80000000).
- R7: Op codes 6 and 7 give a `result` of zero.
- R8: All 64-bit intermediate arithmetic wraps modulo 2^64, with no saturation.
- R9: `out_valid` is high exactly two clock edges after an edge that sampled `in_valid` high, and low otherwise. `result` changes only together with a new `out_valid`.
- R10: A synchronous active-high `rst` clears `out_valid`, the pipeline and `result` to zero.
- R11: Operations issued on consecutive cycles each produce their own result, in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op_sel | input | 3 | Operation code (0..5 defined, 6..7 give zero) |
| mul_a | input | 32 | Signed multiplicand |
| mul_b | input | 32 | Signed multiplier |
| acc_in | input | 32 | Accumulator operand, aligned to the upper half |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Upper word of the final 64-bit value |

## Verification
The hardest cases to reach from the ports are those where the low half of the 64-bit value decides the upper word. These include a borrow from the low half in the subtract forms, a rounding bias that just fails to carry (low half 0x7FFFFFFF), and one that just carries (low half 0x80000000). The cases where the 64-bit sum wraps past its most negative or most positive value are equally hard to reach. The stimulus table builds each of these from operand pairs whose product has a known low half, such as -1 times 1, 2^16 times 2^15, and the most negative operand squared. The same table is then issued back to back, one entry per cycle, to show that successive results stay separate.

// File: rtl/himul_pkg.sv
package himul_pkg;

  typedef enum logic [2:0] {
    HM_MUL     = 3'd0,
    HM_MUL_RND = 3'd1,
    HM_ACC     = 3'd2,
    HM_ACC_RND = 3'd3,
    HM_SUB     = 3'd4,
    HM_SUB_RND = 3'd5
  } hm_op_e;

  typedef struct packed {
    logic use_acc;
    logic negate;
    logic round;
    logic force_zero;
  } hm_ctl_t;

  function automatic hm_ctl_t hm_decode(input logic [2:0] code);
    hm_ctl_t c;
    c = '0;
    case (code)
      HM_MUL:     c = '{use_acc: 1'b0, negate: 1'b0, round: 1'b0, force_zero: 1'b0};
      HM_MUL_RND: c = '{use_acc: 1'b0, negate: 1'b0, round: 1'b1, force_zero: 1'b0};
      HM_ACC:     c = '{use_acc: 1'b1, negate: 1'b0, round: 1'b0, force_zero: 1'b0};
      HM_ACC_RND: c = '{use_acc: 1'b1, negate: 1'b0, round: 1'b1, force_zero: 1'b0};
      HM_SUB:     c = '{use_acc: 1'b1, negate: 1'b1, round: 1'b0, force_zero: 1'b0};
      HM_SUB_RND: c = '{use_acc: 1'b1, negate: 1'b1, round: 1'b1, force_zero: 1'b0};
      default:    c = '{use_acc: 1'b0, negate: 1'b0, round: 1'b0, force_zero: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/himul_capture.sv
module himul_capture #(
  parameter int W  = 32,
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [OW-1:0] op_in,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  c_in,
  output logic          s1_valid,
  output logic [OW-1:0] s1_op,
  output logic [W-1:0]  s1_a,
  output logic [W-1:0]  s1_b,
  output logic [W-1:0]  s1_c
);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_c     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op <= op_in;
        s1_a  <= a_in;
        s1_b  <= b_in;
        s1_c  <= c_in;
      end
    end
  end

endmodule

// File: rtl/himul_datapath.sv
module himul_datapath
  import himul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] hi_word
);

  localparam int PW = 2 * W;
  localparam logic [PW-1:0] BIAS = {{(PW-W){1'b0}}, 1'b1, {(W-1){1'b0}}};

  hm_ctl_t         ctl;
  logic [PW-1:0]   a_ext;
  logic [PW-1:0]   b_ext;
  logic [PW-1:0]   prod;
  logic [PW-1:0]   acc_term;
  logic [PW-1:0]   base;
  logic [PW-1:0]   total;

  always_comb begin
    ctl      = hm_decode(op);
    a_ext    = {{W{a[W-1]}}, a};
    b_ext    = {{W{b[W-1]}}, b};
    prod     = a_ext * b_ext;
    acc_term = {c, {W{1'b0}}};
    if (!ctl.use_acc)
      base = prod;
    else if (ctl.negate)
      base = acc_term - prod;
    else
      base = acc_term + prod;
    total = ctl.round ? (base + BIAS) : base;
  end

  assign hi_word = ctl.force_zero ? '0 : total[PW-1:W];

endmodule

// File: rtl/himul_result_reg.sv
module himul_result_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_word,
  output logic         q_valid,
  output logic [W-1:0] q_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_word  <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid)
        q_word <= d_word;
    end
  end

endmodule

// File: rtl/himul_unit.sv
module himul_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] mul_a,
  input  logic [W-1:0] mul_b,
  input  logic [W-1:0] acc_in,
  output logic         out_valid,
  output logic [W-1:0] result
);

  localparam int OW = 3;

  logic          s1_valid;
  logic [OW-1:0] s1_op;
  logic [W-1:0]  s1_a;
  logic [W-1:0]  s1_b;
  logic [W-1:0]  s1_c;
  logic [W-1:0]  s1_hi;

  himul_capture #(.W(W), .OW(OW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_in    (op_sel),
    .a_in     (mul_a),
    .b_in     (mul_b),
    .c_in     (acc_in),
    .s1_valid (s1_valid),
    .s1_op    (s1_op),
    .s1_a     (s1_a),
    .s1_b     (s1_b),
    .s1_c     (s1_c)
  );

  himul_datapath #(.W(W)) u_dp (
    .op      (s1_op),
    .a       (s1_a),
    .b       (s1_b),
    .c       (s1_c),
    .hi_word (s1_hi)
  );

  himul_result_reg #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (s1_valid),
    .d_word  (s1_hi),
    .q_valid (out_valid),
    .q_word  (result)
  );

endmodule

// File: rtl/himul_unit_chk.sv
module himul_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [2:0]   op_sel,
  input logic [W-1:0] mul_a,
  input logic [W-1:0] mul_b,
  input logic [W-1:0] acc_in,
  input logic         out_valid,
  input logic [W-1:0] result
);

  // R9: a sampled input valid gives an output valid two edges later
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R9: no input valid means no output valid two edges later
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R9: the result word holds while no new result is presented
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(result));

  // R10: the cycle after a reset edge shows a cleared output
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0));

  // R7: the unused codes give zero
  p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[2] && op_sel[1]) |-> ##2 (result == '0));

  // R1: a zero operand in the plain form gives zero
  p_zero_operand_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd0 && (mul_a == '0 || mul_b == '0)) |-> ##2 (result == '0));

endmodule

bind himul_unit himul_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .mul_a     (mul_a),
  .mul_b     (mul_b),
  .acc_in    (acc_in),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/sim_himul_unit.sv
`timescale 1ns/1ps
module sim_himul_unit;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;

  // Expected words worked out by hand from the requirements.
  localparam vec_t TBL [NV] = '{
    '{3'd0, 32'h40000000, 32'h00000004, 32'h0,        32'h00000001, 8'd1},  // R1 2^32
    '{3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h0,        32'hFFFFFFFF, 8'd1},  // R1 -1
    '{3'd0, 32'h80000000, 32'h80000000, 32'h0,        32'h40000000, 8'd1},  // R1 min squared
    '{3'd0, 32'hFFFFFFFD, 32'hFFFFFFFB, 32'h0,        32'h00000000, 8'd1},  // R1 neg*neg
    '{3'd0, 32'h00010000, 32'h00008000, 32'h0,        32'h00000000, 8'd1},  // R1 2^31 truncated
    '{3'd1, 32'h00010000, 32'h00008000, 32'h0,        32'h00000001, 8'd2},  // R2 carries
    '{3'd1, 32'hFFFFFFFF, 32'h00000001, 32'h0,        32'h00000000, 8'd2},  // R2 -1 rounds to 0
    '{3'd1, 32'h7FFFFFFF, 32'h00000001, 32'h0,        32'h00000000, 8'd2},  // R2 no carry
    '{3'd2, 32'h00000002, 32'h00000003, 32'h00000005, 32'h00000005, 8'd3},  // R3
    '{3'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000005, 32'h00000004, 8'd3},  // R3 borrow
    '{3'd3, 32'hFFFFFFFF, 32'h00000001, 32'h00000005, 32'h00000005, 8'd4},  // R4
    '{3'd3, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd4},  // R4 neg acc
    '{3'd4, 32'h00000002, 32'h00000003, 32'h00000005, 32'h00000004, 8'd5},  // R5 borrow
    '{3'd4, 32'hFFFFFFFE, 32'h00000003, 32'h00000000, 32'h00000000, 8'd5},  // R5 minus neg
    '{3'd5, 32'h00000002, 32'h00000003, 32'h00000005, 32'h00000005, 8'd6},  // R6
    '{3'd6, 32'h00000003, 32'h00000004, 32'h00000005, 32'h00000000, 8'd7},  // R7
    '{3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 8'd7},  // R7
    '{3'd2, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'hBFFFFFFE, 8'd8},  // R8 positive wrap
    '{3'd4, 32'h00000001, 32'h00000001, 32'h80000000, 32'h7FFFFFFF, 8'd8},  // R8 negative wrap
    '{3'd5, 32'h80000000, 32'h80000000, 32'h80000000, 32'h40000000, 8'd8}   // R8 wrap + round
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [31:0] mul_a, mul_b, acc_in;
  logic        out_valid;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  himul_unit #(.W(32)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .mul_a(mul_a), .mul_b(mul_b), .acc_in(acc_in),
    .out_valid(out_valid), .result(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1;
    op_sel   = v.op;
    mul_a    = v.a;
    mul_b    = v.b;
    acc_in   = v.c;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    op_sel   = 3'd0;
    mul_a    = 32'h0;
    mul_b    = 32'h0;
    acc_in   = 32'h0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {31'h0, out_valid}, 32'h0);
    check("R10 result", result, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk, one operation at a time (R1..R8)
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      idle();
      @(negedge clk);
      check($sformatf("R%0d vec%0d valid", TBL[i].req, i), {31'h0, out_valid}, 32'h1);
      check($sformatf("R%0d vec%0d result", TBL[i].req, i), result, TBL[i].exp);
    end

    // R9: latency and hold
    @(negedge clk);
    drive(TBL[2]);
    @(negedge clk);
    idle();
    check("R9 not yet valid", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check("R9 valid at two", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    check("R9 valid drops", {31'h0, out_valid}, 32'h0);
    mul_a = 32'h12345678;
    mul_b = 32'h7FFFFFFF;
    op_sel = 3'd3;
    acc_in = 32'h55555555;
    repeat (3) @(negedge clk);
    check("R9 ignored operands", result, 32'h40000000);
    check("R9 idle no valid", {31'h0, out_valid}, 32'h0);
    idle();

    // R11: back-to-back stream
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check($sformatf("R11 stream%0d valid", i - 2), {31'h0, out_valid}, 32'h1);
        check($sformatf("R11 stream%0d result", i - 2), result, TBL[i-2].exp);
      end
      if (i < NV) drive(TBL[i]);
      else idle();
      @(negedge clk);
    end
    idle();

    // R10: reset in mid-flight
    drive(TBL[0]);
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 flush valid", {31'h0, out_valid}, 32'h0);
    check("R10 flush result", result, 32'h0);
    @(negedge clk);
    check("R10 nothing emerges", {31'h0, out_valid}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule